// File: doc/BRIEF.md
# Iterative Feistel Block Cipher Engine

This engine enciphers or deciphers one 64-bit block at a time with a small Feistel network. The block is split into a left half (bits 63:32) and a right half (bits 31:0). One iteration runs per clock. In each iteration a raw 32-bit subkey is added, modulo 2^32, to the left half, and the sum is XORed into the right half. Four such iterations make two full rounds, and the halves are swapped at the end. Decryption runs the same datapath with the subkeys applied in reverse order.

The 128-bit key has no dedicated port. It enters over the 64-bit data input in two back-to-back cycles and is kept as four 32-bit subkeys. Once a key is present, a caller places a block on the data input together with a one-cycle encrypt or decrypt strobe. The result appears on a registered output together with a one-cycle completion pulse. The output then keeps that value until the next operation finishes.

Top module: `feistel_core`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, `dout` is all zeros and `done` is low.
- R2: An iteration replaces the left half with ((subkey + left) mod 2^32) XOR right and the right half with the old left half. Both updates happen on the same clock edge, and a carry out of bit 31 is discarded.
- R3: An operation runs exactly four iterations, one per clock. The result is the final halves swapped, so `dout` = {right, left} with the right half in bits 63:32.
- R4: A key load takes two cycles. When `key_load` is high, din[63:32] becomes subkey 0 and din[31:0] becomes subkey 1. On the next clock, with `key_load` not required, din[63:32] becomes subkey 2 and din[31:0] becomes subkey 3.
- R5: Encryption applies the subkeys in the order 0, 1, 2, 3.
- R6: Decryption applies the subkeys in the order 3, 2, 1, 0. Decrypting a ciphertext with the key that produced it returns the plaintext, and this also holds for the all-zero key.
- R7: If a strobe is sampled on clock edge k, `done` is high for exactly one cycle, from edge k+4 to edge k+5, and the new result is on `dout` from edge k+4.
- R8: `dout` changes only on the edge that raises `done`. Between operations it holds the last result.
- R9: A strobe that arrives while an operation is running is ignored. It does not change the running operation's result, and it does not produce a second `done`.
- R10: If `enc_go` and `dec_go` are both high in a cycle where a start is accepted, the engine encrypts.
- R11: `key_load` is ignored while an operation runs, so the stored key stays unchanged. A start strobe is ignored if it comes in the same cycle as `key_load` or in the second key cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 64 | Data block or key half, depending on the cycle |
| key_load | input | 1 | Marks the first of two key cycles |
| enc_go | input | 1 | Starts an encryption of `din` |
| dec_go | input | 1 | Starts a decryption of `din` |
| dout | output | 64 | Registered result block |
| done | output | 1 | One-cycle pulse when `dout` takes a new result |

## Verification
The bench builds the engine with its default parameters: 32-bit halves and four iterations. This reaches the full 32-bit carry wrap in the modular add and all four subkey slots, each of which is distinguishable by value. Keys with four distinct words expose any swap in the load mapping or in the encrypt and decrypt orderings. Strobes placed in busy cycles and in key cycles reach the ignore rules and the encrypt-over-decrypt priority.

// File: rtl/feistel_pkg.sv
package feistel_pkg;

  typedef enum logic {
    DIR_ENC = 1'b0,
    DIR_DEC = 1'b1
  } dir_e;

  // Subkey slot used at a given iteration for a given direction.
  function automatic int unsigned order_pick(dir_e d, int unsigned it, int unsigned n);
    return (d == DIR_ENC) ? it : (n - 1 - it);
  endfunction

endpackage

// File: rtl/feistel_keybank.sv
module feistel_keybank #(
  parameter int HALF_W  = 32,
  parameter int NUM_SUB = 4,
  localparam int SW  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
  localparam int NPH = NUM_SUB / 2,
  localparam int PW  = (NPH > 1) ? $clog2(NPH) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [2*HALF_W-1:0]               din,
  input  logic                              key_load,
  input  logic                              lock,
  input  logic [SW-1:0]                     sel_idx,
  output logic [HALF_W-1:0]                 subkey,
  output logic [NUM_SUB-1:0][HALF_W-1:0]    keys_flat,
  output logic                              key_busy
);

  logic [PW-1:0]                  phase_q;
  logic [PW-1:0]                  slot_sel;
  logic                           wr_en;
  logic [NPH-1:0]                 slot_hit;
  logic [NUM_SUB-1:0][HALF_W-1:0] keys_q;

  assign key_busy = (phase_q != '0);
  assign slot_sel = phase_q;
  assign wr_en    = key_busy || (key_load && !lock);

  for (genvar g = 0; g < NPH; g++) begin : g_slot
    assign slot_hit[g] = wr_en && (slot_sel == PW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keys_q  <= '0;
      phase_q <= '0;
    end else begin
      for (int s = 0; s < NPH; s++) begin
        if (slot_hit[s]) begin
          keys_q[2*s]   <= din[2*HALF_W-1:HALF_W];
          keys_q[2*s+1] <= din[HALF_W-1:0];
        end
      end
      if (wr_en) begin
        if (slot_sel == PW'(NPH - 1)) phase_q <= '0;
        else                          phase_q <= slot_sel + 1'b1;
      end
    end
  end

  assign subkey    = keys_q[sel_idx];
  assign keys_flat = keys_q;

endmodule

// File: rtl/feistel_round.sv
module feistel_round #(
  parameter int HALF_W = 32
) (
  input  logic [HALF_W-1:0] left_i,
  input  logic [HALF_W-1:0] right_i,
  input  logic [HALF_W-1:0] subkey_i,
  output logic [HALF_W-1:0] left_o,
  output logic [HALF_W-1:0] right_o
);

  // Round function: raw key word added to the half, carry dropped.
  function automatic logic [HALF_W-1:0] mix(logic [HALF_W-1:0] k, logic [HALF_W-1:0] h);
    return k + h;
  endfunction

  assign left_o  = mix(subkey_i, left_i) ^ right_i;
  assign right_o = left_i;

endmodule

// File: rtl/feistel_ctrl.sv
module feistel_ctrl #(
  parameter int NUM_ROUNDS = 4,
  localparam int IW = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enc_go,
  input  logic                 dec_go,
  input  logic                 key_load,
  input  logic                 key_busy,
  output logic                 start_acc,
  output logic                 busy,
  output feistel_pkg::dir_e    dir,
  output logic [IW-1:0]        iter,
  output logic                 iter_last
);

  assign start_acc = !busy && !key_load && !key_busy && (enc_go || dec_go);
  assign iter_last = busy && (iter == IW'(NUM_ROUNDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      dir  <= feistel_pkg::DIR_ENC;
      iter <= '0;
    end else if (start_acc) begin
      busy <= 1'b1;
      dir  <= enc_go ? feistel_pkg::DIR_ENC : feistel_pkg::DIR_DEC;
      iter <= '0;
    end else if (busy) begin
      if (iter_last) begin
        busy <= 1'b0;
        iter <= '0;
      end else begin
        iter <= iter + 1'b1;
      end
    end
  end

endmodule

// File: rtl/feistel_core.sv
module feistel_core #(
  parameter int HALF_W     = 32,
  parameter int NUM_ROUNDS = 4,
  localparam int BLK_W = 2 * HALF_W,
  localparam int IW    = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] din,
  input  logic             key_load,
  input  logic             enc_go,
  input  logic             dec_go,
  output logic [BLK_W-1:0] dout,
  output logic             done
);

  logic                              start_acc;
  logic                              busy;
  feistel_pkg::dir_e                 dir;
  logic [IW-1:0]                     iter;
  logic                              iter_last;
  logic                              key_busy;
  logic [IW-1:0]                     sel_idx;
  logic [HALF_W-1:0]                 subkey;
  logic [NUM_ROUNDS-1:0][HALF_W-1:0] keys_flat;
  logic [HALF_W-1:0]                 left_q, right_q, left_n, right_n;
  logic                              finish_now;

  feistel_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .enc_go(enc_go), .dec_go(dec_go),
    .key_load(key_load), .key_busy(key_busy), .start_acc(start_acc),
    .busy(busy), .dir(dir), .iter(iter), .iter_last(iter_last)
  );

  assign sel_idx = IW'(feistel_pkg::order_pick(dir, 32'(iter), NUM_ROUNDS));

  feistel_keybank #(.HALF_W(HALF_W), .NUM_SUB(NUM_ROUNDS)) keys_i (
    .clk(clk), .rst_n(rst_n), .din(din), .key_load(key_load), .lock(busy),
    .sel_idx(sel_idx), .subkey(subkey), .keys_flat(keys_flat), .key_busy(key_busy)
  );

  feistel_round #(.HALF_W(HALF_W)) round_i (
    .left_i(left_q), .right_i(right_q), .subkey_i(subkey),
    .left_o(left_n), .right_o(right_n)
  );

  assign finish_now = busy && iter_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
      dout    <= '0;
      done    <= 1'b0;
    end else begin
      if (start_acc) begin
        left_q  <= din[BLK_W-1:HALF_W];
        right_q <= din[HALF_W-1:0];
      end else if (busy) begin
        left_q  <= left_n;
        right_q <= right_n;
      end
      if (finish_now) dout <= {right_n, left_n};
      done <= finish_now;
    end
  end

endmodule

// File: rtl/feistel_core_chk.sv
module feistel_core_chk #(
  parameter int HALF_W     = 32,
  parameter int NUM_ROUNDS = 4,
  parameter int IW         = 2
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [2*HALF_W-1:0]               dout,
  input logic                              done,
  input logic                              enc_go,
  input logic                              start_acc,
  input logic                              busy,
  input logic                              iter_last,
  input logic [IW-1:0]                     iter,
  input feistel_pkg::dir_e                 dir,
  input logic [NUM_ROUNDS-1:0][HALF_W-1:0] keys_flat
);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_to_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && iter_last) |=> (done && !busy));

  p_dout_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(dout));

  p_first_iter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (busy && iter == '0));

  p_iter_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !iter_last) |=> (busy && iter == IW'($past(iter) + 1'b1)));

  p_dir_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !iter_last) |=> $stable(dir));

  p_enc_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && enc_go) |=> (dir == feistel_pkg::DIR_ENC));

  p_key_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(keys_flat));

endmodule

bind feistel_core feistel_core_chk #(
  .HALF_W(HALF_W), .NUM_ROUNDS(NUM_ROUNDS), .IW(IW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .dout(dout), .done(done), .enc_go(enc_go),
  .start_acc(start_acc), .busy(busy), .iter_last(iter_last), .iter(iter),
  .dir(dir), .keys_flat(keys_flat)
);

// File: tb/feistel_core_tb.sv
`timescale 1ns/1ps
module feistel_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] din = '0;
  logic        key_load = 1'b0;
  logic        enc_go = 1'b0;
  logic        dec_go = 1'b0;
  logic [63:0] dout;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  feistel_core dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .key_load(key_load),
    .enc_go(enc_go), .dec_go(dec_go), .dout(dout), .done(done)
  );

  // Reference: subkey w sits at key[127-32*w -: 32].
  function automatic logic [63:0] model(logic [127:0] key, logic [63:0] blk, bit decrypt);
    logic [31:0] a, b, t, k;
    a = blk[63:32];
    b = blk[31:0];
    for (int step = 0; step < 4; step++) begin
      int w;
      w = decrypt ? 3 - step : step;
      k = key[127 - 32*w -: 32];
      t = b ^ 32'(k + a);
      b = a;
      a = t;
    end
    return {b, a};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_key(logic [127:0] key);
    @(negedge clk); din = key[127:64]; key_load = 1'b1;
    @(negedge clk); din = key[63:0];   key_load = 1'b0;
    @(negedge clk); din = '0;
  endtask

  // Strobe at one negedge, released at the next.
  task automatic strobe(logic [63:0] blk, bit e, bit d);
    @(negedge clk); din = blk; enc_go = e; dec_go = d;
    @(negedge clk); din = '0; enc_go = 1'b0; dec_go = 1'b0;
  endtask

  task automatic expect_result(string req, logic [63:0] exp);
    repeat (3) begin
      @(negedge clk);
      chk(req, "done early", 64'(done), 64'd0);
    end
    @(negedge clk);
    chk(req, "done pulse", 64'(done), 64'd1);
    chk(req, "dout", dout, exp);
    @(negedge clk);
    chk(req, "done width", 64'(done), 64'd0);
    chk(req, "dout after", dout, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "dout reset", dout, 64'd0);
    chk("R1", "done reset", 64'(done), 64'd0);
  endtask

  task automatic t_zero_key();
    logic [63:0] p, c;
    p = 64'h0123_4567_89AB_CDEF;
    c = model('0, p, 1'b0);
    load_key('0);
    strobe(p, 1'b1, 1'b0);
    expect_result("R5", c);
    strobe(c, 1'b0, 1'b1);
    expect_result("R6", p);
  endtask

  task automatic t_patterns(logic [127:0] key);
    logic [63:0] pats [4];
    pats[0] = 64'h0000_0000_0000_0000;
    pats[1] = 64'hFFFF_FFFF_0000_0001;
    pats[2] = 64'hDEAD_BEEF_CAFE_F00D;
    pats[3] = 64'h8000_0000_7FFF_FFFF;
    load_key(key);
    for (int i = 0; i < 4; i++) begin
      logic [63:0] c;
      c = model(key, pats[i], 1'b0);
      strobe(pats[i], 1'b1, 1'b0);
      expect_result("R2 R3 R4 R5", c);
      strobe(c, 1'b0, 1'b1);
      expect_result("R6", pats[i]);
    end
  endtask

  task automatic t_busy_ignore(logic [127:0] key);
    logic [63:0] p1, p2;
    p1 = 64'h1111_2222_3333_4444;
    p2 = 64'h5555_6666_7777_8888;
    @(negedge clk); din = p1; enc_go = 1'b1;
    @(negedge clk); din = p2; enc_go = 1'b0; dec_go = 1'b1;
    @(negedge clk); din = '0; dec_go = 1'b0;
    chk("R9", "done early", 64'(done), 64'd0);
    repeat (2) begin
      @(negedge clk);
      chk("R9", "done early", 64'(done), 64'd0);
    end
    @(negedge clk);
    chk("R9", "done pulse", 64'(done), 64'd1);
    chk("R9", "dout first op", dout, model(key, p1, 1'b0));
    repeat (6) begin
      @(negedge clk);
      chk("R9", "no second done", 64'(done), 64'd0);
    end
  endtask

  task automatic t_priority(logic [127:0] key);
    logic [63:0] p;
    p = 64'h0F0F_0F0F_F0F0_F0F0;
    strobe(p, 1'b1, 1'b1);
    expect_result("R10", model(key, p, 1'b0));
  endtask

  task automatic t_key_while_busy(logic [127:0] key);
    logic [63:0] p;
    p = 64'hA5A5_A5A5_5A5A_5A5A;
    @(negedge clk); din = p; enc_go = 1'b1;
    @(negedge clk); enc_go = 1'b0; din = 64'hFFFF_0000_FFFF_0000; key_load = 1'b1;
    @(negedge clk); key_load = 1'b0; din = 64'h1234_1234_1234_1234;
    @(negedge clk); din = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R11", "done", 64'(done), 64'd1);
    chk("R11", "dout old key", dout, model(key, p, 1'b0));
    strobe(p, 1'b1, 1'b0);
    expect_result("R11", model(key, p, 1'b0));
  endtask

  task automatic t_start_in_key(logic [127:0] key2);
    logic [63:0] p, held;
    p = 64'h7777_0000_0000_7777;
    held = dout;
    @(negedge clk); din = key2[127:64]; key_load = 1'b1; enc_go = 1'b1;
    @(negedge clk); din = key2[63:0];   key_load = 1'b0;
    @(negedge clk); din = '0; enc_go = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk("R11", "start in key cycle", 64'(done), 64'd0);
      chk("R8", "dout held", dout, held);
    end
    strobe(p, 1'b1, 1'b0);
    expect_result("R4 R11", model(key2, p, 1'b0));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] k1, k2;
    k1 = 128'h0000_0001_1000_0000_F00F_F00F_89AB_CDEF;
    k2 = 128'hFFFF_FFFF_0000_0003_0000_0500_0700_0000;
    #1;
    chk("R1", "dout in reset", dout, 64'd0);
    chk("R1", "done in reset", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero_key();
    t_patterns(k1);
    t_busy_ignore(k1);
    t_priority(k1);
    t_key_while_busy(k1);
    t_start_in_key(k2);
    t_patterns(k2);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule